// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

A 32-bit watchdog sits behind a simple word-wide register port. Software loads a reload value, turns the dog on through a control register, and must keep feeding it by writing a 16-bit key to a restart register. While running, a status counter counts down once per selected tick: every peripheral clock, or a slower microsecond tick made by a prescaler on that clock. When the count runs out, the block can raise a one-cycle interrupt pulse and drive a reset pulse of programmable width, polarity and drive style.

Polarity and drive style are held as two flags in the pulse-width register and change only when a recognised byte code sits in the top byte of a write; the low bits of the same write set the pulse length. A memory-controller-reset input vetoes the watchdog action: an expiry that happens while it is high clears the control register and does nothing else.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset the status counter and the reload value read 0x03EF1480, control reads 0, the pulse-width register reads 0x000000FF, the reset output sits at its inactive level 1 and its output enable is 0.
- R2: Only accesses with all four byte enables set and a word-aligned offset take effect; any other write is ignored and any other read returns 0.
- R3: A write to offset 0x08 whose low 16 bits are 0x4755 loads the status counter from the reload value (offset 0x04); any other key leaves the counter untouched.
- R4: A control write (offset 0x0C) with bit 0 set while the dog is off stores the value and starts counting from the reload value; with bit 0 clear while the dog is on it stores the value and freezes the counter; a write that does not change bit 0 is ignored.
- R5: While running, the counter drops by one every clock when control bit 4 is clear and by one every PRESCALE clocks when it is set.
- R6: The counter expires on the tick that takes it from 1 to 0; it then stays at 0 until restarted.
- R7: On expiry with control bit 2 set, the interrupt output is high for exactly one clock.
- R8: On expiry with control bit 1 set, the reset output is active for as many clocks as the pulse-width field holds; bit 31 of the pulse-width register selects active-high (1) or active-low (0), bit 30 selects push-pull (output enable always 1) or open-drain (output enable only while active).
- R9: A pulse-width write (offset 0x18) with top byte 0xA5 sets bit 31, 0x5A clears it, 0xA8 sets bit 30, 0x8A clears it, any other top byte leaves both flags; the low PW_WIDTH bits of the data replace the width field.
- R10: An expiry while the memory-reset input is high produces no interrupt and no reset pulse and clears the control register.
- R11: Offset 0x08 and undefined offsets read 0; writes to undefined offsets and to the status counter (offset 0x00) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| mem_rst_i | input | 1 | Memory-controller reset active; vetoes expiry action |
| irq_o | output | 1 | One-cycle expiry interrupt |
| wdt_rst_o | output | 1 | Reset pulse level |
| wdt_rst_oe_o | output | 1 | Reset pulse output enable |

## Verification
The hardest state to reach is the exact cycle of expiry with a chosen action mix, because the default reload value is tens of millions of ticks. The bench first writes a reload of a few counts and a short pulse width, then enables the dog and counts falling edges from the enabling write, so the interrupt cycle, the pulse length and the output enable are all checked against cycle numbers worked out from the requirements. The memory-reset veto is reached the same way with the veto input held high across the expiry, and the prescaled mode is checked over a window that is a whole multiple of the divider so that the prescaler phase cannot matter.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFF_STATUS  = 8'h00;
  localparam logic [7:0] OFF_RELOAD  = 8'h04;
  localparam logic [7:0] OFF_RESTART = 8'h08;
  localparam logic [7:0] OFF_CTRL    = 8'h0C;
  localparam logic [7:0] OFF_PWIDTH  = 8'h18;

  localparam logic [15:0] FEED_KEY   = 16'h4755;

  localparam logic [7:0] CODE_HIGH   = 8'hA5;
  localparam logic [7:0] CODE_LOW    = 8'h5A;
  localparam logic [7:0] CODE_PP     = 8'hA8;
  localparam logic [7:0] CODE_OD     = 8'h8A;

  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_SLOW = 4;

  localparam int PB_HIGH = 31;
  localparam int PB_PP   = 30;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESCALE = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(PRESCALE);
      logic [CW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else if (div_q == CW'(PRESCALE - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == CW'(PRESCALE - 1));
    end
  endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int          CW      = 32,
  parameter logic [31:0] RST_VAL = 32'h03EF1480
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          tick_i,
  output logic [CW-1:0] count_o,
  output logic          running_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o  = run_q && tick_i && !load_i && !stop_i && (cnt_q <= CW'(1));
  assign count_o   = cnt_q;
  assign running_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(RST_VAL);
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= start_i;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (expire_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: one step per tick
  p_dec_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && tick_i && !load_i && !stop_i && cnt_q > CW'(1) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R6: stopped at zero after expiry
  p_stop_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !run_q && cnt_q == '0);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PW_WIDTH = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PW_WIDTH-1:0] width_i,
  input  logic                act_high_i,
  input  logic                push_pull_i,
  output logic                rst_o,
  output logic                rst_oe_o
);
  logic [PW_WIDTH-1:0] left_q;
  logic                active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else if (start_i && left_q == '0) left_q <= width_i;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign active   = (left_q != '0);
  assign rst_o    = act_high_i ? active : !active;
  assign rst_oe_o = push_pull_i || active;

  // R8: pulse only follows an expiry request
  p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active) |-> $past(start_i));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int          PRESCALE   = 24,
  parameter int          PW_WIDTH   = 20,
  parameter logic [31:0] RELOAD_RST = 32'h03EF1480
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        mem_rst_i,
  output logic        irq_o,
  output logic        wdt_rst_o,
  output logic        wdt_rst_oe_o
);
  import wdog_pkg::*;

  localparam logic [31:0] PW_MASK = 32'((64'd1 << PW_WIDTH) - 1);
  localparam logic [31:0] FLAG_MASK = (32'd1 << PB_HIGH) | (32'd1 << PB_PP);

  logic [31:0] reload_q, ctrl_q, pw_q, count;
  logic        acc, wr, rd, tick_slow, tick, expire, running;
  logic        en_wr, dis_wr, feed, irq_q;
  logic [31:0] pw_flags;

  assign acc = req_i && (be_i == 4'hF) && (addr_i[1:0] == 2'b00);
  assign wr  = acc && we_i;
  assign rd  = acc && !we_i;

  assign en_wr  = wr && addr_i == OFF_CTRL &&  wdata_i[CB_EN] && !ctrl_q[CB_EN];
  assign dis_wr = wr && addr_i == OFF_CTRL && !wdata_i[CB_EN] &&  ctrl_q[CB_EN];
  assign feed   = wr && addr_i == OFF_RESTART && wdata_i[15:0] == FEED_KEY;

  wdog_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_slow));

  assign tick = ctrl_q[CB_SLOW] ? tick_slow : 1'b1;

  wdog_counter #(.CW(32), .RST_VAL(RELOAD_RST)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(en_wr || feed), .load_val_i(reload_q),
    .start_i(en_wr || (feed && ctrl_q[CB_EN])),
    .stop_i(dis_wr), .tick_i(tick),
    .count_o(count), .running_o(running), .expire_o(expire));

  // flag update from magic top byte
  always_comb begin
    pw_flags = pw_q;
    unique case (wdata_i[31:24])
      CODE_HIGH: pw_flags[PB_HIGH] = 1'b1;
      CODE_LOW:  pw_flags[PB_HIGH] = 1'b0;
      CODE_PP:   pw_flags[PB_PP]   = 1'b1;
      CODE_OD:   pw_flags[PB_PP]   = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RELOAD_RST;
      ctrl_q   <= '0;
      pw_q     <= 32'h0000_00FF;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= expire && ctrl_q[CB_IRQ] && !mem_rst_i;
      if (wr && addr_i == OFF_RELOAD) reload_q <= wdata_i;
      if (en_wr || dis_wr) ctrl_q <= wdata_i;
      else if (expire && mem_rst_i) ctrl_q <= '0;
      if (wr && addr_i == OFF_PWIDTH)
        pw_q <= (pw_flags & ~PW_MASK) | (wdata_i & PW_MASK);
    end
  end

  wdog_pulse #(.PW_WIDTH(PW_WIDTH)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(expire && ctrl_q[CB_RST] && !mem_rst_i),
    .width_i(pw_q[PW_WIDTH-1:0]),
    .act_high_i(pw_q[PB_HIGH]), .push_pull_i(pw_q[PB_PP]),
    .rst_o(wdt_rst_o), .rst_oe_o(wdt_rst_oe_o));

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFF_STATUS: rdata_o = count;
        OFF_RELOAD: rdata_o = reload_q;
        OFF_CTRL:   rdata_o = ctrl_q;
        OFF_PWIDTH: rdata_o = pw_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  // R7: interrupt is a single-cycle pulse
  p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R10: veto clears control and suppresses interrupt
  p_veto_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && mem_rst_i |=> ctrl_q == '0 && !irq_o);
  // R9: flags unchanged by non-pulse-width writes
  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == OFF_PWIDTH) |=> (pw_q & FLAG_MASK) == ($past(pw_q) & FLAG_MASK));
  // R4: counter frozen when not running and not loaded
  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running && !en_wr && !feed |=> $stable(count));
endmodule

// File: tb/wdog_ctrl_bench.sv
module wdog_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, mem_rst = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wrst, wrst_oe;
  int          n_run = 0, n_fail = 0;

  localparam int PSC = 4;

  always #4 clk = ~clk;

  wdog_ctrl #(.PRESCALE(PSC)) u_wdog_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .mem_rst_i(mem_rst),
    .irq_o(irq), .wdt_rst_o(wrst), .wdt_rst_oe_o(wrst_oe));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr_be(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk); req = 0; we = 0; be = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_be(a, d, 4'hF);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    req = 1; we = 0; addr = a; be = 4'hF;
    #1 v = rdata;
    req = 0; be = '0;
  endtask

  // count output activity over n falling edges
  task automatic watch(input int n, output int c_irq, output int c_act_hi, output int c_oe);
    c_irq = 0; c_act_hi = 0; c_oe = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_irq += int'(irq); c_act_hi += int'(wrst); c_oe += int'(wrst_oe);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 status", v, 32'h03EF1480);
    rd(8'h04, v); chk("R1 reload", v, 32'h03EF1480);
    rd(8'h0C, v); chk("R1 ctrl", v, 0);
    rd(8'h18, v); chk("R1 pwidth", v, 32'hFF);
    chk("R1 rst level", wrst, 1); chk("R1 rst oe", wrst_oe, 0);
  endtask

  task automatic t_access;
    logic [31:0] v;
    wr(8'h04, 32'd40);
    wr_be(8'h04, 32'd99, 4'h3);
    rd(8'h04, v); chk("R2 partial write ignored", v, 40);
    wr(8'h05, 32'd77);
    rd(8'h04, v); chk("R2 misaligned write ignored", v, 40);
    req = 1; we = 0; addr = 8'h04; be = 4'h1; #1 v = rdata; req = 0; be = 0;
    chk("R2 partial read zero", v, 0);
  endtask

  task automatic t_undef;
    logic [31:0] v;
    wr(8'h00, 32'h1234);
    rd(8'h00, v); chk("R11 status read-only", v, 32'h03EF1480);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R11 undefined reads zero", v, 0);
    rd(8'h08, v); chk("R11 restart reads zero", v, 0);
    rd(8'h04, v); chk("R11 undefined write no effect", v, 40);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(8'h08, 32'h0000_4756);
    rd(8'h00, v); chk("R3 bad key ignored", v, 32'h03EF1480);
    wr(8'h08, 32'hABCD_4755);
    rd(8'h00, v); chk("R3 key loads counter", v, 40);
    repeat (3) @(negedge clk);
    rd(8'h00, v); chk("R3 disabled feed does not run", v, 40);
  endtask

  task automatic t_ctrl_fast;
    logic [31:0] v;
    wr(8'h04, 32'd50);
    wr(8'h0C, 32'h1);
    repeat (10) @(negedge clk);
    rd(8'h00, v); chk("R5 per-clock decrement", v, 40);
    wr(8'h0C, 32'h5);
    rd(8'h0C, v); chk("R4 same-enable write ignored", v, 1);
    wr(8'h08, 32'h4755);
    rd(8'h00, v); chk("R3 feed while running reloads", v, 50);
    wr(8'h0C, 32'h0);
    rd(8'h0C, v); chk("R4 disable stores", v, 0);
    rd(8'h00, v);
    repeat (5) @(negedge clk);
    begin
      logic [31:0] w;
      rd(8'h00, w); chk("R4 disable freezes counter", w, v);
    end
  endtask

  task automatic t_slow;
    logic [31:0] v;
    wr(8'h04, 32'd100);
    wr(8'h0C, 32'h11);
    repeat (3 * PSC) @(negedge clk);
    rd(8'h00, v); chk("R5 prescaled decrement", v, 97);
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_pwreg;
    logic [31:0] v;
    wr(8'h18, 32'hA500_0003); rd(8'h18, v); chk("R9 set high", v, 32'h8000_0003);
    wr(8'h18, 32'hA800_0003); rd(8'h18, v); chk("R9 set push-pull", v, 32'hC000_0003);
    wr(8'h18, 32'h7700_0004); rd(8'h18, v); chk("R9 other code keeps flags", v, 32'hC000_0004);
    wr(8'h18, 32'h5A00_0004); rd(8'h18, v); chk("R9 clear high", v, 32'h4000_0004);
    wr(8'h18, 32'h8AFF_FFFF); rd(8'h18, v); chk("R9 clear pp, 20-bit field", v, 32'h000F_FFFF);
  endtask

  task automatic t_expire_irq;
    logic [31:0] v;
    int ci, ch, co;
    wr(8'h04, 32'd3);
    wr(8'h0C, 32'h5);
    repeat (2) @(negedge clk);
    chk("R7 no irq before expiry", irq, 0);
    @(negedge clk);
    chk("R7 irq on expiry cycle", irq, 1);
    rd(8'h00, v); chk("R6 counter at zero", v, 0);
    watch(10, ci, ch, co);
    chk("R7 irq single cycle", ci, 0);
    rd(8'h00, v); chk("R6 stays at zero", v, 0);
    chk("R8 no pulse without reset bit", ch, 10);
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_pulse;
    int ci, ch, co;
    wr(8'h18, 32'hA500_0003);
    wr(8'h04, 32'd2);
    wr(8'h0C, 32'h3);
    watch(20, ci, ch, co);
    chk("R8 active-high width", ch, 3);
    chk("R8 open-drain oe", co, 3);
    chk("R7 no irq when bit clear", ci, 0);
    wr(8'h0C, 32'h0);
    wr(8'h18, 32'h5A00_0004);
    wr(8'h18, 32'hA800_0004);
    wr(8'h0C, 32'h3);
    watch(20, ci, ch, co);
    chk("R8 active-low width", 20 - ch, 4);
    chk("R8 push-pull oe", co, 20);
    wr(8'h0C, 32'h0);
    wr(8'h18, 32'h8A00_00FF);
  endtask

  task automatic t_veto;
    logic [31:0] v;
    int ci, ch, co;
    mem_rst = 1;
    wr(8'h18, 32'h0000_0003);
    wr(8'h04, 32'd2);
    wr(8'h0C, 32'h7);
    watch(15, ci, ch, co);
    mem_rst = 0;
    chk("R10 no irq", ci, 0);
    chk("R10 no pulse", ch, 15);
    rd(8'h0C, v); chk("R10 ctrl cleared", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_access();
    t_undef();
    t_restart();
    t_ctrl_fast();
    t_slow();
    t_pwreg();
    t_expire_irq();
    t_pulse();
    t_veto();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule